// File: doc/BRIEF.md
# Display Controller Guarded Configuration Registers

This block holds the configuration registers of a segment display controller and decides, on each bus write, which fields may change. It has one main control register, one counter-enable register and three frame-counter registers. A write comes in on a single-cycle port (strobe, address, data). Some fields are guarded. The phase-count and bias fields of the control register can change only while the controller is stopped. Each frame-counter register can change only while its own bit in the counter-enable register is clear. When a guarded write is refused, the block drops it without any side effect and raises a one-cycle `write_ignored` flag. Every stored value is always visible, both on dedicated outputs and through an address-selected read port.

A two-state machine tracks whether the controller is running. **ST_IDLE** (stopped) is the reset state. The transition *start* moves it to **ST_ACTIVE** when a control write has the run bit at 1. The transition *stop* returns it to ST_IDLE when a control write has the run bit at 0. The transition *soft reset* forces ST_IDLE from either state when a control write has the reset bit at 1. The guard decision always uses the state before the write. A write that starts the controller can therefore still load the guarded fields. A write that stops it cannot.

Address map: 0 = control, 1 = counter enables (bits [2:0], bit i guards counter i), 2/3/4 = frame counters 0/1/2. Control layout: bit 0 run, bit 1 soft reset (always reads 0), bits [4:2] phase count, bits [6:5] bias, bit 7 blank.

Top module: `dispcfg_regs`

## Requirements
- R1: After reset, all stored fields, all outputs and `write_ignored` are 0, and the state is ST_IDLE.
- R2: A control write made in ST_IDLE loads phase (bits [4:2]) and bias (bits [6:5]). This includes a write that also sets run (bit 0) to 1.
- R3: A control write made in ST_ACTIVE leaves phase and bias unchanged. This includes a write that clears run to 0. The run bit itself still follows the written value.
- R4: The blank field (bit 7) takes the written value on every control write that is not a soft reset, in either state.
- R5: A write to frame counter i (address 2+i) stores the data when counter-enable bit i is 0.
- R6: A write to frame counter i is dropped when counter-enable bit i is 1, and the other counters are not affected.
- R7: `write_ignored` is 1 for exactly the cycle after a dropped write, meaning a control write in ST_ACTIVE or a guarded frame-counter write. It is 0 after any other cycle.
- R8: A control write with bit 1 at 1 clears every register to 0 and forces ST_IDLE. No other field of that write is stored, and `write_ignored` stays 0.
- R9: `rd_data` returns the stored value at `rd_addr` in the layouts above, zero-extended. Unmapped addresses (5 to 7) read 0.
- R10: The state moves ST_IDLE to ST_ACTIVE on a control write with run 1, and ST_ACTIVE to ST_IDLE on a control write with run 0. `run` is 1 exactly in ST_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Stored value at rd_addr |
| run | output | 1 | Controller running (ST_ACTIVE) |
| phase_sel | output | 3 | Phase-count field |
| bias_sel | output | 2 | Bias field |
| blank | output | 1 | Blank field |
| cnt_en | output | NUM_FC | Counter enable bits |
| fc_value | output | NUM_FC*FC_W | Frame counter values, counter i at [i*FC_W +: FC_W] |
| write_ignored | output | 1 | Pulse: previous write was dropped |

## Verification
Some rules can be checked on every cycle, and the assertions do that. Guarded fields hold after a control write in ST_ACTIVE, and a guarded counter holds after a write to it. An open counter takes the written data. A soft reset lands in ST_IDLE with cleared fields, start writes enter ST_ACTIVE, and `write_ignored` never rises without a write the cycle before. Other behaviour only shows up in the bench's ordered scenarios. One such case is the same-write corner: a start write carries new phase and bias and they are taken, while a stop write's fields are refused. Others are the unmapped read addresses, and a soft reset leaving the counters cleared after writes that were earlier dropped.

// File: rtl/dispcfg_pkg.sv
package dispcfg_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } run_state_e;

    // Control register layout
    localparam int CTRL_W      = 8;
    localparam int BIT_RUN     = 0;
    localparam int BIT_SWRST   = 1;
    localparam int PHASE_LSB   = 2;
    localparam int BIAS_LSB    = 5;
    localparam int BIT_BLANK   = 7;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_CNTEN  = 1;
    localparam int FC_BASE     = 2;

    typedef struct packed {
        logic       blank;
        logic [1:0] bias;
        logic [2:0] phase;
    } ctrl_fields_t;
endpackage

// File: rtl/dispcfg_ctrl_unit.sv
module dispcfg_ctrl_unit
    import dispcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CTRL_W-1:0] wr_bits,
    output logic              soft_rst,
    output logic              run,
    output ctrl_fields_t      fields,
    output logic              locked_drop
);
    run_state_e state_q, state_d;
    ctrl_fields_t fields_q;

    assign soft_rst = wr_hit && wr_bits[BIT_SWRST];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!soft_rst && wr_hit && wr_bits[BIT_RUN]) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (soft_rst || (wr_hit && !wr_bits[BIT_RUN])) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (soft_rst) begin
            fields_q <= '0;
        end else if (wr_hit) begin
            fields_q.blank <= wr_bits[BIT_BLANK];
            if (state_q == ST_IDLE) begin
                fields_q.phase <= wr_bits[PHASE_LSB +: 3];
                fields_q.bias  <= wr_bits[BIAS_LSB +: 2];
            end
        end
    end

    always_comb begin
        run         = (state_q == ST_ACTIVE);
        fields      = fields_q;
        locked_drop = wr_hit && !soft_rst && (state_q == ST_ACTIVE);
    end

    assert_locked_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !soft_rst && run) |=> ($stable(fields.phase) && $stable(fields.bias)));

    assert_swrst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!run && fields == '0));

    assert_enter_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !soft_rst && wr_bits[BIT_RUN]) |=> run);
endmodule

// File: rtl/dispcfg_fc_unit.sv
module dispcfg_fc_unit #(
    parameter int FC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            sel_wr,
    input  logic            guard_en,
    input  logic [FC_W-1:0] wr_val,
    output logic [FC_W-1:0] value,
    output logic            drop
);
    logic [FC_W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    value_q <= '0;
        else if (clr)                  value_q <= '0;
        else if (sel_wr && !guard_en)  value_q <= wr_val;
    end

    assign value = value_q;
    assign drop  = sel_wr && guard_en;

    assert_guard_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && guard_en && !clr) |=> $stable(value));

    assert_open_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !guard_en && !clr) |=> (value == $past(wr_val)));
endmodule

// File: rtl/dispcfg_regs.sv
module dispcfg_regs
    import dispcfg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int FC_W   = 16,
    parameter int NUM_FC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   run,
    output logic [2:0]             phase_sel,
    output logic [1:0]             bias_sel,
    output logic                   blank,
    output logic [NUM_FC-1:0]      cnt_en,
    output logic [NUM_FC*FC_W-1:0] fc_value,
    output logic                   write_ignored
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_CNTEN = ADDR_W'(ADDR_CNTEN);

    logic              ctrl_hit, soft_rst, ctrl_drop;
    ctrl_fields_t      fields;
    logic [NUM_FC-1:0] en_q;
    logic [NUM_FC-1:0] fc_drop;
    logic [FC_W-1:0]   fc_q [NUM_FC];
    logic              ign_q;

    assign ctrl_hit = wr_en && (wr_addr == A_CTRL);

    dispcfg_ctrl_unit ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (ctrl_hit),
        .wr_bits     (wr_data[CTRL_W-1:0]),
        .soft_rst    (soft_rst),
        .run         (run),
        .fields      (fields),
        .locked_drop (ctrl_drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           en_q <= '0;
        else if (soft_rst)                    en_q <= '0;
        else if (wr_en && wr_addr == A_CNTEN) en_q <= wr_data[NUM_FC-1:0];
    end

    for (genvar i = 0; i < NUM_FC; i++) begin : g_fc
        logic sel;
        assign sel = wr_en && (wr_addr == ADDR_W'(FC_BASE + i));
        dispcfg_fc_unit #(.FC_W(FC_W)) fc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (soft_rst),
            .sel_wr   (sel),
            .guard_en (en_q[i]),
            .wr_val   (wr_data[FC_W-1:0]),
            .value    (fc_q[i]),
            .drop     (fc_drop[i])
        );
        assign fc_value[i*FC_W +: FC_W] = fc_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ign_q <= 1'b0;
        else        ign_q <= ctrl_drop || (|fc_drop);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[BIT_RUN]           = run;
            rd_data[PHASE_LSB +: 3]    = fields.phase;
            rd_data[BIAS_LSB +: 2]     = fields.bias;
            rd_data[BIT_BLANK]         = fields.blank;
        end else if (rd_addr == A_CNTEN) begin
            rd_data[NUM_FC-1:0] = en_q;
        end
        for (int k = 0; k < NUM_FC; k++) begin
            if (rd_addr == ADDR_W'(FC_BASE + k)) rd_data = DATA_W'(fc_q[k]);
        end
    end

    assign phase_sel     = fields.phase;
    assign bias_sel      = fields.bias;
    assign blank         = fields.blank;
    assign cnt_en        = en_q;
    assign write_ignored = ign_q;

    assert_ignore_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        write_ignored |-> $past(wr_en));

    assert_swrst_no_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!write_ignored && cnt_en == '0));
endmodule

// File: tb/dispcfg_regs_tb_top.sv
module dispcfg_regs_tb_top;
    localparam int VW = 1 + 3 + 2 + 1 + 3 + 48 + 1 + 16;

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        run, blank, write_ignored;
    logic [2:0]  phase_sel, cnt_en;
    logic [1:0]  bias_sel;
    logic [47:0] fc_value;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Bench-side model state
    logic        m_run = 0, m_blank = 0;
    logic [2:0]  m_phase = 0, m_en = 0;
    logic [1:0]  m_bias = 0;
    logic [15:0] m_fc [3] = '{16'h0, 16'h0, 16'h0};

    always #4 clk = ~clk;

    dispcfg_regs dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .run (run), .phase_sel (phase_sel), .bias_sel (bias_sel),
        .blank (blank), .cnt_en (cnt_en), .fc_value (fc_value),
        .write_ignored (write_ignored)
    );

    task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                        input logic [2:0] ra, input string tag);
        exp_t e;
        logic ign = 1'b0;
        logic [15:0] rv;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        if (we) begin
            if (a == 3'd0) begin
                if (d[1]) begin
                    m_run = 0; m_blank = 0; m_phase = 0; m_bias = 0; m_en = 0;
                    for (int i = 0; i < 3; i++) m_fc[i] = 16'h0;
                end else begin
                    if (!m_run) begin m_phase = d[4:2]; m_bias = d[6:5]; end
                    else ign = 1'b1;
                    m_blank = d[7];
                    m_run   = d[0];
                end
            end else if (a == 3'd1) begin
                m_en = d[2:0];
            end else if (a >= 3'd2 && a <= 3'd4) begin
                if (m_en[a-2]) ign = 1'b1;
                else m_fc[a-2] = d;
            end
        end
        case (ra)
            3'd0: rv = {8'h0, m_blank, m_bias, m_phase, 1'b0, m_run};
            3'd1: rv = {13'h0, m_en};
            3'd2: rv = m_fc[0];
            3'd3: rv = m_fc[1];
            3'd4: rv = m_fc[2];
            default: rv = 16'h0;
        endcase
        e.v   = {m_run, m_phase, m_bias, m_blank, m_en, m_fc[2], m_fc[1], m_fc[0], ign, rv};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares one expected item per cycle, after the edge settles
    always @(posedge clk) begin
        exp_t e;
        logic [VW-1:0] got;
        #2;
        if (exp_q.size() > 0) begin
            e   = exp_q.pop_front();
            got = {run, phase_sel, bias_sel, blank, cnt_en, fc_value, write_ignored, rd_data};
            n_chk++;
            if (got !== e.v) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", e.tag, got, e.v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 3'd0, 16'h0, 3'd0, "R1 reset state");
        // R2: stopped, load phase=5 bias=2 blank=1
        step(1, 3'd0, 16'h00D4, 3'd0, "R2 idle write loads guarded fields");
        // R2 R10: start write also loads phase=3 bias=1
        step(1, 3'd0, 16'h002D, 3'd0, "R2 R10 start write takes fields");
        // R3 R7: running, phase=7 refused
        step(1, 3'd0, 16'h001D, 3'd0, "R3 R7 running write drops fields");
        // R4: blank set while running
        step(1, 3'd0, 16'h00A5, 3'd0, "R4 blank follows while running");
        step(0, 3'd0, 16'h0, 3'd0, "R7 idle cycle clears pulse");
        // R3 R10: stop write with phase=1 refused
        step(1, 3'd0, 16'h0004, 3'd0, "R3 R10 stop write keeps fields");
        step(1, 3'd0, 16'h0044, 3'd0, "R2 stopped write loads again");
        // R5: counters open
        step(1, 3'd2, 16'h1234, 3'd2, "R5 fc0 open write");
        step(1, 3'd3, 16'hBEEF, 3'd3, "R5 fc1 open write");
        step(1, 3'd4, 16'h0F0F, 3'd4, "R5 fc2 open write");
        step(1, 3'd1, 16'h0002, 3'd1, "R9 enable register readback");
        // R6 R7: fc1 guarded
        step(1, 3'd3, 16'h5555, 3'd3, "R6 R7 fc1 guarded write dropped");
        step(1, 3'd2, 16'hAAAA, 3'd2, "R5 fc0 still open");
        step(1, 3'd4, 16'h7777, 3'd3, "R6 fc2 write leaves fc1");
        step(0, 3'd0, 16'h0, 3'd6, "R9 unmapped read is zero");
        step(1, 3'd6, 16'hFFFF, 3'd7, "R9 unmapped write no effect");
        // R8: start, then soft reset while running and counters guarded
        step(1, 3'd0, 16'h0001, 3'd0, "R10 start");
        step(1, 3'd0, 16'h00FF, 3'd2, "R8 soft reset clears all");
        step(0, 3'd0, 16'h0, 3'd1, "R8 enables cleared");
        step(1, 3'd3, 16'h0101, 3'd3, "R5 fc1 open after reset");
        step(0, 3'd0, 16'h0, 3'd0, "R1 R10 idle after reset");
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule